// File: doc/BRIEF.md
# Register-Bus Datapath

This block is a single-cycle processor datapath built around seven general-purpose registers. Two source selectors place operands on an A bus and a B bus. A shared arithmetic/logic unit combines them, and a destination decoder returns the result to at most one register on the next rising clock edge. All steering comes from one 14-bit control word on an input port, so an external sequencer or a test driver can issue one micro-operation per clock.

A source code of zero takes the operand from an external data input instead of a register. A destination code of zero writes nothing. The unit's result is always visible on the external output, whether or not a register is written. A 4-bit status register records carry, sign, zero and overflow for each result, and it updates on the same clock edge as the register write.

Top module: `regbus_datapath`

## Requirements
- R1: While `rst_n` is low, all seven registers and the status flags become zero. After reset, reading any register through the A bus returns 0 and `flags` reads 4'b0000.
- R2: Control word bits [13:11] select the A-bus source and bits [10:8] select the B-bus source. Code 000 selects `ext_in` and codes 001..111 select register 1..7.
- R3: Control word bits [7:5] select the destination. Code 000 leaves every register unchanged. Code k (1..7) loads the result into register k only, at the next rising edge.
- R4: `ext_out` carries the current result combinationally in every cycle, including cycles with destination code 000.
- R5: Code 00001 gives A+1 and code 00010 gives A+B, both modulo 256. C is the carry out of bit 7.
- R6: Code 00101 gives A−B, computed as A + ~B + 1. Code 00110 gives A−1. C is the carry out of bit 7, which is 1 when no borrow occurs. For example, 8'hF0 − 8'h14 gives 8'hDC with C=1, S=1, Z=0, V=0.
- R7: Code 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B and 01110 gives NOT A. XOR of a source with itself yields zero, which clears a destination register.
- R8: Code 10000 shifts A right logically, with C taken from the old bit 0. Code 11000 shifts A left, filling bit 0 with zero, with C taken from the old bit 7.
- R9: `flags` is {C,S,Z,V} with C at bit 3. S is result bit 7 and Z is 1 when the result is zero. For the arithmetic codes, V is the XOR of the carries into and out of bit 7. For all other codes, V is 0. For codes other than arithmetic and shift, C is 0.
- R10: Any operation code not listed above passes A through unchanged, with C=0 and V=0.
- R11: `flags` takes the status of the result that was present before a rising edge, on the same edge that writes that result to its destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 14 | {A source, B source, destination, operation} |
| ext_in | input | 8 | External operand for source code 000 |
| ext_out | output | 8 | Current result of the arithmetic/logic unit |
| flags | output | 4 | Registered status {C,S,Z,V} |

## Verification
A register written wrongly, or written when it should be left alone, stays hidden until a later control word reads it back. The bench therefore follows every write sequence with a transfer of each register to `ext_out`, so a stale or corrupted value shows up within a few cycles. A wrong status bit shows up on `flags` one edge after the operation that produced it. A wrong result shows up on `ext_out` in the same cycle as the control word.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

   localparam int SEL_W = 3;
   localparam int OP_W  = 5;
   localparam int CW_W  = 3 * SEL_W + OP_W;

   typedef enum logic [OP_W-1:0] {
      OP_PASS = 5'b00000,
      OP_INC  = 5'b00001,
      OP_ADD  = 5'b00010,
      OP_SUB  = 5'b00101,
      OP_DEC  = 5'b00110,
      OP_AND  = 5'b01000,
      OP_OR   = 5'b01010,
      OP_XOR  = 5'b01100,
      OP_NOT  = 5'b01110,
      OP_SHR  = 5'b10000,
      OP_SHL  = 5'b11000
   } alu_op_e;

   typedef struct packed {
      logic c;
      logic s;
      logic z;
      logic v;
   } status_t;

endpackage

// File: rtl/regbus_srcmux.sv
module regbus_srcmux #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 7,
   parameter int SEL_W    = 3
) (
   input  logic [SEL_W-1:0]           sel,
   input  logic [DATA_W-1:0]          ext_in,
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   output logic [DATA_W-1:0]          bus
);

   always_comb begin
      bus = ext_in;
      for (int i = 1; i <= NUM_REGS; i++) begin
         if (sel == SEL_W'(i)) begin
            bus = regs_flat[i*DATA_W-1 -: DATA_W];
         end
      end
   end

endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 7,
   parameter int SEL_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SEL_W-1:0]           dest,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   logic [NUM_REGS:1] wr_en;

   for (genvar g = 1; g <= NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] q;

      assign wr_en[g] = (dest == SEL_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en[g]) begin
            q <= wdata;
         end
      end

      assign regs_flat[g*DATA_W-1 -: DATA_W] = q;
   end

endmodule

// File: rtl/regbus_alu.sv
module regbus_alu
   import regbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   opr,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y,
   output status_t           st
);

   logic [DATA_W-1:0] b_op;
   logic              cin;
   logic [DATA_W:0]   full_sum;
   logic [DATA_W-1:0] low_sum;

   always_comb begin
      b_op = '0;
      cin  = 1'b0;
      case (opr)
         OP_INC: cin = 1'b1;
         OP_ADD: b_op = b;
         OP_SUB: begin
            b_op = ~b;
            cin  = 1'b1;
         end
         OP_DEC: b_op = '1;
         default: ;
      endcase
   end

   assign full_sum = {1'b0, a} + {1'b0, b_op} + {{DATA_W{1'b0}}, cin};
   assign low_sum  = {1'b0, a[DATA_W-2:0]} + {1'b0, b_op[DATA_W-2:0]}
                   + {{(DATA_W-1){1'b0}}, cin};

   always_comb begin
      y    = a;
      st.c = 1'b0;
      st.v = 1'b0;
      case (opr)
         OP_INC, OP_ADD, OP_SUB, OP_DEC: begin
            y    = full_sum[DATA_W-1:0];
            st.c = full_sum[DATA_W];
            st.v = full_sum[DATA_W] ^ low_sum[DATA_W-1];
         end
         OP_AND: y = a & b;
         OP_OR:  y = a | b;
         OP_XOR: y = a ^ b;
         OP_NOT: y = ~a;
         OP_SHR: begin
            y    = {1'b0, a[DATA_W-1:1]};
            st.c = a[0];
         end
         OP_SHL: begin
            y    = {a[DATA_W-2:0], 1'b0};
            st.c = a[DATA_W-1];
         end
         default: y = a;
      endcase
      st.s = y[DATA_W-1];
      st.z = (y == '0);
   end

endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath
   import regbus_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW_W-1:0]   ctrl_word,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] ext_out,
   output logic [3:0]        flags
);

   localparam int MAX_REGS = (1 << SEL_W) - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("regbus_datapath: DATA_W must be at least 2");
   end
   if (NUM_REGS < 1 || NUM_REGS > MAX_REGS) begin : g_bad_regs
      $error("regbus_datapath: NUM_REGS out of range for the selector width");
   end

   logic [SEL_W-1:0]           sel_a;
   logic [SEL_W-1:0]           sel_b;
   logic [SEL_W-1:0]           sel_d;
   logic [OP_W-1:0]            op;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;
   logic [DATA_W-1:0]          bus_a;
   logic [DATA_W-1:0]          bus_b;
   logic [DATA_W-1:0]          result;
   status_t                    st_next;
   status_t                    st_q;

   assign {sel_a, sel_b, sel_d, op} = ctrl_word;

   regbus_srcmux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_mux_a (
      .sel       (sel_a),
      .ext_in    (ext_in),
      .regs_flat (regs_flat),
      .bus       (bus_a)
   );

   regbus_srcmux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_mux_b (
      .sel       (sel_b),
      .ext_in    (ext_in),
      .regs_flat (regs_flat),
      .bus       (bus_b)
   );

   regbus_alu #(.DATA_W(DATA_W)) u_alu (
      .opr (op),
      .a   (bus_a),
      .b   (bus_b),
      .y   (result),
      .st  (st_next)
   );

   regbus_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .dest      (sel_d),
      .wdata     (result),
      .regs_flat (regs_flat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= st_next;
      end
   end

   assign ext_out = result;
   assign flags   = st_q;

endmodule

// File: rtl/regbus_checker.sv
module regbus_checker
   import regbus_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [CW_W-1:0]            ctrl_word,
   input logic [DATA_W-1:0]          ext_in,
   input logic [DATA_W-1:0]          ext_out,
   input logic [3:0]                 flags,
   input logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   logic [SEL_W-1:0] c_a;
   logic [SEL_W-1:0] c_b;
   logic [SEL_W-1:0] c_d;
   logic [OP_W-1:0]  c_op;

   assign {c_a, c_b, c_d, c_op} = ctrl_word;

   // R9: Z and S captured from the previous result
   assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (flags[1] == ($past(ext_out) == '0)));

   assert_sign_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (flags[2] == $past(ext_out[DATA_W-1])));

   // R2: source 000 with transfer puts the external input on the output
   assert_ext_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_a == '0 && c_op == OP_PASS) |-> (ext_out == ext_in));

   // R7: XOR of identical sources is zero
   assert_xor_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_XOR && c_a == c_b) |-> (ext_out == '0));

   // R10: logic codes never raise overflow
   assert_logic_novf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (c_op == OP_AND || c_op == OP_OR || c_op == OP_XOR || c_op == OP_NOT)
      |=> (flags[0] == 1'b0));

   for (genvar g = 1; g <= NUM_REGS; g++) begin : g_reg_chk
      // R3: the selected register takes the result, the others hold
      assert_dest_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (c_d == SEL_W'(g)) |=> (regs_flat[g*DATA_W-1 -: DATA_W] == $past(ext_out)));

      assert_dest_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (c_d != SEL_W'(g)) |=> $stable(regs_flat[g*DATA_W-1 -: DATA_W]));
   end

endmodule

bind regbus_datapath regbus_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_word (ctrl_word),
   .ext_in    (ext_in),
   .ext_out   (ext_out),
   .flags     (flags),
   .regs_flat (regs_flat)
);

// File: tb/test_regbus_datapath.sv
`timescale 1ns/1ps
module test_regbus_datapath;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] ctrl_word = '0;
   logic [7:0]  ext_in = '0;
   logic [7:0]  ext_out;
   logic [3:0]  flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0] m_reg [1:7];

   always #2.5 clk = ~clk;

   regbus_datapath i_regbus_datapath (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_word (ctrl_word),
      .ext_in    (ext_in),
      .ext_out   (ext_out),
      .flags     (flags)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference: returns result and {C,S,Z,V}
   task automatic ref_alu(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                          output logic [7:0] y, output logic [3:0] f);
      logic c, v;
      c = 1'b0;
      v = 1'b0;
      case (op)
         5'b00001: begin y = a + 8'd1; c = (a == 8'hFF); v = (a == 8'h7F); end
         5'b00010: begin
            y = a + b;
            c = (int'(a) + int'(b)) > 255;
            v = (a[7] == b[7]) && (y[7] != a[7]);
         end
         5'b00101: begin
            y = a - b;
            c = (a >= b);
            v = (a[7] != b[7]) && (y[7] != a[7]);
         end
         5'b00110: begin y = a - 8'd1; c = (a != 8'h00); v = (a == 8'h80); end
         5'b01000: y = a & b;
         5'b01010: y = a | b;
         5'b01100: y = a ^ b;
         5'b01110: y = ~a;
         5'b10000: begin y = a >> 1; c = a[0]; end
         5'b11000: begin y = a << 1; c = a[7]; end
         default:  y = a;
      endcase
      f = {c, y[7], (y == 8'h00), v};
   endtask

   function automatic string tag_of(input logic [4:0] op);
      case (op)
         5'b00000: return "R2 R4";
         5'b00001, 5'b00010: return "R5";
         5'b00101, 5'b00110: return "R6";
         5'b01000, 5'b01010, 5'b01100, 5'b01110: return "R7";
         5'b10000, 5'b11000: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic step(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                       input logic [4:0] op, input logic [7:0] x, input string tag);
      logic [7:0] a, b, y;
      logic [3:0] f;
      @(negedge clk);
      ctrl_word = {sa, sb, sd, op};
      ext_in    = x;
      a = (sa == 3'd0) ? x : m_reg[sa];
      b = (sb == 3'd0) ? x : m_reg[sb];
      ref_alu(op, a, b, y, f);
      #1;
      check(ext_out, y, tag);
      @(posedge clk);
      #1;
      check({4'h0, flags}, {4'h0, f}, "R9 R11 flags");
      if (sd != 3'd0) m_reg[sd] = y;
   endtask

   task automatic readback_all(input string tag);
      for (int k = 1; k <= 7; k++) begin
         step(3'(k), 3'd0, 3'd0, 5'b00000, 8'h00, tag);
      end
   endtask

   initial begin
      for (int k = 1; k <= 7; k++) m_reg[k] = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      check({4'h0, flags}, 8'h00, "R1 flags after reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R1: every register reads zero
      for (int k = 1; k <= 7; k++) begin
         step(3'(k), 3'd0, 3'd0, 5'b00000, 8'hA5, "R1 register zero");
      end

      // R2 R3: load distinct values through the external source
      for (int k = 1; k <= 7; k++) begin
         step(3'd0, 3'd0, 3'(k), 5'b00000, 8'(k * 37 + 3), "R2 load");
      end
      readback_all("R3 readback");

      // R3 R4: destination 000 shows the result but writes nothing
      step(3'd1, 3'd2, 3'd0, 5'b00010, 8'h00, "R4 no-dest result");
      step(3'd0, 3'd0, 3'd0, 5'b00000, 8'h77, "R4 ext passthrough");
      readback_all("R3 unchanged after no-dest");

      // R6: worked subtraction example
      step(3'd0, 3'd0, 3'd2, 5'b00000, 8'hF0, "R2 load");
      step(3'd0, 3'd0, 3'd3, 5'b00000, 8'h14, "R2 load");
      step(3'd2, 3'd3, 3'd4, 5'b00101, 8'h00, "R6 example diff");
      check({4'h0, flags}, 8'h0C, "R6 example flags");
      step(3'd4, 3'd0, 3'd0, 5'b00000, 8'h00, "R6 stored diff");
      check(ext_out, 8'hDC, "R6 stored literal");

      // R7: XOR self clears each register
      for (int k = 1; k <= 7; k++) begin
         step(3'(k), 3'(k), 3'(k), 5'b01100, 8'h00, "R7 xor self");
      end
      readback_all("R7 cleared");

      // Near-exhaustive sweep: A from ext_in, B from register 1
      for (int bi = 0; bi < 16; bi++) begin
         logic [7:0] bval;
         bval = 8'(bi * 17) ^ ((bi & 1) != 0 ? 8'h80 : 8'h00);
         step(3'd0, 3'd0, 3'd1, 5'b00000, bval, "R2 load B");
         for (int ai = 0; ai < 256; ai++) begin
            for (int oi = 0; oi < 13; oi++) begin
               logic [4:0] op;
               logic [2:0] sd;
               case (oi)
                  0: op = 5'b00000;  1: op = 5'b00001;  2: op = 5'b00010;
                  3: op = 5'b00101;  4: op = 5'b00110;  5: op = 5'b01000;
                  6: op = 5'b01010;  7: op = 5'b01100;  8: op = 5'b01110;
                  9: op = 5'b10000; 10: op = 5'b11000; 11: op = 5'b00011;
                  default: op = 5'b11111;
               endcase
               sd = ((ai + oi) % 7 == 0) ? 3'd0 : 3'(((ai + oi) % 7) + 1);
               step(3'd0, 3'd1, sd, op, 8'(ai), tag_of(op));
            end
         end
         readback_all("R3 sweep state");
      end

      // Register-to-register operations on sweep leftovers
      for (int k = 2; k <= 7; k++) begin
         step(3'(k), 3'(k - 1), 3'(k), 5'b00010, 8'h00, "R5 reg add");
         step(3'(k), 3'(k - 1), 3'(k - 1), 5'b00101, 8'h00, "R6 reg sub");
      end
      readback_all("R3 final state");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1..none actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule